// File: doc/BRIEF.md
# System Control Register Bank

This block is the byte-wide control register file of a multi-function companion device. A host reaches it over a simple 8-bit bus: one address byte, one data byte, a write strobe and a read strobe. Every register, whatever its logical width, is reached one byte at a time at consecutive offsets, with the least significant byte at the lowest offset.

The bank has three jobs. It merges eight interrupt lines from sub-blocks into one interrupt output through a mask. It holds the general-purpose output levels and output enables for 24 pins, and reports which pins changed their driven level after each write. It also keeps the clock, PLL and miscellaneous configuration bytes so software reads back what it wrote. It has no clock, PLL or input-edge behaviour of its own. Read data is registered, and the interrupt status follows the sub-block lines one cycle later.

Top module: `sysctl_regbank`

## Requirements
- R1: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00; writes to either offset leave those values unchanged.
- R2: Bit i of the interrupt status byte at 0x50 equals sub-interrupt line i as sampled on the previous clock edge; writes to 0x50 have no effect.
- R3: The interrupt output is high exactly when the status byte ANDed with the mask byte at 0x52 is non-zero.
- R4: The mask byte at 0x52 and the routing byte at 0x54 read back the last value written.
- R5: The 16-bit registers at 0x60, 0x8C, 0x90, 0x98, 0x9A and 0xE4 (low byte at the base, high byte at base+1) and the 32-bit register at 0x9C..0x9F keep each byte separately and read it back.
- R6: The three-byte arrays at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84, 0x88 and the single bytes at 0xA0, 0xA1, 0xE0, 0xFC, 0xFF read back the last value written.
- R7: Output data bytes at 0x78..0x7A and output enable bytes at 0x7C..0x7E read back as written; byte n holds pins 8n (bit 0) to 8n+7 (bit 7).
- R8: The level output for pin p equals data bit p AND enable bit p, updated on the edge that takes the write, and changes at no other time.
- R9: In the cycle after a data or enable write, the change output has bit p set exactly for the pins whose level changed; it is zero in every other cycle.
- R10: Unmapped offsets (for example 0x6B and 0xFE) read 0x00, and writes to them change no register.
- R11: Reset clears every register, the level and change outputs and the interrupt output.
- R12: Read data appears on the clock edge that samples the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sub_irq_in | input | 8 | Interrupt lines from the sub-blocks |
| irq_out | output | 1 | Masked, merged interrupt |
| gpo_level | output | 24 | Driven level of each output pin |
| gpo_change | output | 24 | One-cycle pulse per pin whose level changed |

## Verification
Each result is due one edge after its cause: read data on the edge that samples the read strobe, the status byte and interrupt output on the edge after a line moves, and level and change on the edge that takes a write. The bench drives inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between cause and check. The change pulse is checked at that falling edge and again one cycle later, where it must be zero. Ignored writes are proven by a read of the same offset, or of its neighbour, after the write.

// File: rtl/sysctl_pkg.sv
// Shared constants and the address map of the configuration byte store.
// Assumes an 8-bit offset space and byte-wide data.
package sysctl_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [7:0] REV_LO_OFS   = 8'h08;
    localparam logic [7:0] REV_HI_OFS   = 8'h09;
    localparam logic [7:0] REV_VALUE    = 8'h03;
    localparam logic [7:0] STAT_OFS     = 8'h50;
    localparam logic [7:0] MASK_OFS     = 8'h52;
    localparam logic [7:0] GPO_DATA_OFS = 8'h78;
    localparam logic [7:0] GPO_EN_OFS   = 8'h7C;

    localparam int CFG_SLOTS = 43;
    localparam int SLOT_W    = $clog2(CFG_SLOTS);

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    // Map an offset onto a storage slot of the configuration store.
    function automatic slot_t cfg_slot(input logic [7:0] a);
        slot_t s;
        int    o;
        int    base;
        int    first;
        int    last;
        o     = int'(a);
        base  = -1;
        first = 0;
        last  = 0;
        if (o == 'h54)                  begin base = 0;  first = 'h54; end
        else if (o >= 'h60 && o <= 'h61) begin base = 1;  first = 'h60; end
        else if (o >= 'h64 && o <= 'h66) begin base = 3;  first = 'h64; end
        else if (o >= 'h68 && o <= 'h6A) begin base = 6;  first = 'h68; end
        else if (o >= 'h6C && o <= 'h6E) begin base = 9;  first = 'h6C; end
        else if (o >= 'h70 && o <= 'h72) begin base = 12; first = 'h70; end
        else if (o >= 'h80 && o <= 'h82) begin base = 15; first = 'h80; end
        else if (o >= 'h84 && o <= 'h86) begin base = 18; first = 'h84; end
        else if (o >= 'h88 && o <= 'h8A) begin base = 21; first = 'h88; end
        else if (o >= 'h8C && o <= 'h8D) begin base = 24; first = 'h8C; end
        else if (o >= 'h90 && o <= 'h91) begin base = 26; first = 'h90; end
        else if (o >= 'h98 && o <= 'h9F) begin base = 28; first = 'h98; end
        else if (o >= 'hA0 && o <= 'hA1) begin base = 36; first = 'hA0; end
        else if (o == 'hE0)              begin base = 38; first = 'hE0; end
        else if (o >= 'hE4 && o <= 'hE5) begin base = 39; first = 'hE4; end
        else if (o == 'hFC)              begin base = 41; first = 'hFC; end
        else if (o == 'hFF)              begin base = 42; first = 'hFF; end
        last  = base + o - first;
        s.hit = (base >= 0);
        s.idx = s.hit ? SLOT_W'(last) : '0;
        return s;
    endfunction
endpackage

// File: rtl/sysctl_irq_agg.sv
// Interrupt merge: samples the sub-block lines into a status register each
// cycle and drives one output from status AND mask.
// Assumes LINES <= 8 so status and mask each fit one bus byte.
module sysctl_irq_agg #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             mask_we,
    input  logic [LINES-1:0] mask_wdata,
    output logic [LINES-1:0] status,
    output logic [LINES-1:0] mask,
    output logic             irq
);
    logic [LINES-1:0] status_q;
    logic [LINES-1:0] mask_q;

    // Status follows the lines with one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= lines;
    end

    // Mask is loaded by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Merged interrupt.
    always_comb irq = |(status_q & mask_q);

    assign status = status_q;
    assign mask   = mask_q;
endmodule

// File: rtl/sysctl_gpo.sv
// Output pin registers: per-byte data and enable, the effective level and a
// one-cycle change vector against the level of the previous cycle.
// Assumes data bytes and enable bytes each sit at consecutive offsets.
module sysctl_gpo #(
    parameter int         BYTES    = 3,
    parameter logic [7:0] DATA_OFS = 8'h78,
    parameter logic [7:0] EN_OFS   = 8'h7C,
    localparam int        PINS     = 8 * BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [PINS-1:0] data_q,
    output logic [PINS-1:0] en_q,
    output logic [PINS-1:0] level,
    output logic [PINS-1:0] change
);
    logic [PINS-1:0] prev_q;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam logic [7:0] D_OFS = DATA_OFS + 8'(b);
        localparam logic [7:0] E_OFS = EN_OFS + 8'(b);

        // Data byte b is loaded by a write to its offset.
        always_ff @(posedge clk) begin
            if (!rst_n)                     data_q[8*b +: 8] <= '0;
            else if (wr && addr == D_OFS)   data_q[8*b +: 8] <= wdata;
        end

        // Enable byte b is loaded by a write to its offset.
        always_ff @(posedge clk) begin
            if (!rst_n)                     en_q[8*b +: 8] <= '0;
            else if (wr && addr == E_OFS)   en_q[8*b +: 8] <= wdata;
        end
    end

    // Effective driven level.
    always_comb level = data_q & en_q;

    // Level of the previous cycle, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Pins whose level moved on the last edge.
    always_comb change = level ^ prev_q;
endmodule

// File: rtl/sysctl_cfg_store.sv
// Configuration byte store: SLOTS read/write bytes addressed by slot index.
// Assumes the caller maps offsets to slots and qualifies the write.
module sysctl_cfg_store #(
    parameter int  SLOTS  = 43,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Slot s is loaded by a write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                        slot_q[s] <= '0;
            else if (we && idx == IDX_W'(s))   slot_q[s] <= wdata;
        end
    end

    // Read selection by index.
    always_comb begin
        rdata = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (idx == IDX_W'(s)) rdata = slot_q[s];
        end
    end
endmodule

// File: rtl/sysctl_regbank.sv
// Top of the system control register bank: offset decode, read mux and
// registered read data over the interrupt, output pin and config stores.
// Assumes at most one of bus_wr/bus_rd per cycle, one byte per access.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int  IRQ_LINES = 8,
    parameter int  GPO_BYTES = 3,
    localparam int GPO_PINS  = 8 * GPO_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DW-1:0]       bus_rdata,
    input  logic [IRQ_LINES-1:0] sub_irq_in,
    output logic                irq_out,
    output logic [GPO_PINS-1:0] gpo_level,
    output logic [GPO_PINS-1:0] gpo_change
);
    logic [IRQ_LINES-1:0] irq_status;
    logic [IRQ_LINES-1:0] irq_mask;
    logic [GPO_PINS-1:0]  gpo_data;
    logic [GPO_PINS-1:0]  gpo_en;
    logic [DW-1:0]        cfg_rdata;
    logic [DW-1:0]        rd_mux;
    logic [DW-1:0]        rdata_q;
    slot_t                slot;

    // Offset to config slot.
    always_comb slot = cfg_slot(bus_addr);

    sysctl_irq_agg #(.LINES(IRQ_LINES)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (sub_irq_in),
        .mask_we    (bus_wr && bus_addr == MASK_OFS),
        .mask_wdata (bus_wdata[IRQ_LINES-1:0]),
        .status     (irq_status),
        .mask       (irq_mask),
        .irq        (irq_out)
    );

    sysctl_gpo #(
        .BYTES    (GPO_BYTES),
        .DATA_OFS (GPO_DATA_OFS),
        .EN_OFS   (GPO_EN_OFS)
    ) u_gpo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .data_q (gpo_data),
        .en_q   (gpo_en),
        .level  (gpo_level),
        .change (gpo_change)
    );

    sysctl_cfg_store #(.SLOTS(CFG_SLOTS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && slot.hit),
        .idx   (slot.idx),
        .wdata (bus_wdata),
        .rdata (cfg_rdata)
    );

    // Read data selection; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == REV_LO_OFS)      rd_mux = REV_VALUE;
        else if (bus_addr == STAT_OFS)   rd_mux[IRQ_LINES-1:0] = irq_status;
        else if (bus_addr == MASK_OFS)   rd_mux[IRQ_LINES-1:0] = irq_mask;
        else if (slot.hit)               rd_mux = cfg_rdata;
        for (int b = 0; b < GPO_BYTES; b++) begin
            if (bus_addr == GPO_DATA_OFS + 8'(b)) rd_mux = gpo_data[8*b +: 8];
            if (bus_addr == GPO_EN_OFS + 8'(b))   rd_mux = gpo_en[8*b +: 8];
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Property checker for the register bank, observing its ports only.
module sysctl_regbank_chk #(
    parameter int IRQ_LINES = 8,
    parameter int GPO_PINS  = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [7:0]           bus_rdata,
    input logic [IRQ_LINES-1:0] sub_irq_in,
    input logic                 irq_out,
    input logic [GPO_PINS-1:0]  gpo_level,
    input logic [GPO_PINS-1:0]  gpo_change
);
    // R1
    rev_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h08) |=> bus_rdata == 8'h03);

    // R3
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sub_irq_in) == '0) |-> !irq_out);

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(gpo_level));

    // R9
    change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpo_change != '0) |-> ($past(bus_wr) &&
            $past(bus_addr) >= 8'h78 && $past(bus_addr) <= 8'h7E));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'hFE) |=> bus_rdata == 8'h00);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (gpo_level == '0 && gpo_change == '0 && !irq_out));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .IRQ_LINES (IRQ_LINES),
    .GPO_PINS  (GPO_PINS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .sub_irq_in (sub_irq_in),
    .irq_out    (irq_out),
    .gpo_level  (gpo_level),
    .gpo_change (gpo_change)
);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  sub_irq_in = '0;
    logic        irq_out;
    logic [23:0] gpo_level;
    logic [23:0] gpo_change;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sysctl_regbank u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .sub_irq_in (sub_irq_in),
        .irq_out    (irq_out),
        .gpo_level  (gpo_level),
        .gpo_change (gpo_change)
    );

    // {offset, write data, expected read-back, requirement number}
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        {8'h60, 8'hA5, 8'hA5, 8'd5},   // R5 low byte
        {8'h61, 8'h3C, 8'h3C, 8'd5},   // R5 high byte
        {8'h9C, 8'h11, 8'h11, 8'd5},   // R5 32-bit byte 0
        {8'h9F, 8'h44, 8'h44, 8'd5},   // R5 32-bit byte 3
        {8'h9A, 8'h5E, 8'h5E, 8'd5},   // R5
        {8'h66, 8'h5A, 8'h5A, 8'd6},   // R6 array
        {8'h6A, 8'h21, 8'h21, 8'd6},   // R6 array
        {8'h6B, 8'hFF, 8'h00, 8'd10},  // R10 gap after array
        {8'h8A, 8'h77, 8'h77, 8'd6},   // R6
        {8'hA1, 8'h9D, 8'h9D, 8'd6},   // R6 single byte
        {8'hFF, 8'hC3, 8'hC3, 8'd6},   // R6 single byte
        {8'hE5, 8'hB2, 8'hB2, 8'd5},   // R5
        {8'h54, 8'h81, 8'h81, 8'd4},   // R4 routing
        {8'h52, 8'h0F, 8'h0F, 8'd4},   // R4 mask
        {8'h08, 8'hFF, 8'h03, 8'd1},   // R1
        {8'h09, 8'hFF, 8'h00, 8'd1},   // R1
        {8'h50, 8'hFF, 8'h00, 8'd2},   // R2 status write ignored
        {8'hFE, 8'h12, 8'h00, 8'd10}   // R10
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 level", gpo_level, 0);
        check("R11 change", gpo_change, 0);
        check("R11 irq", irq_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_byte(8'h60, r); check("R11 cfg", r, 0);

        for (int i = 0; i < NV; i++) begin
            wr_byte(VEC[i][31:24], VEC[i][23:16]);
            rd_byte(VEC[i][31:24], r);
            check($sformatf("R%0d table %0d", VEC[i][7:0], i), r, VEC[i][15:8]);
        end
        // R10 unmapped write left neighbour intact
        rd_byte(8'h6A, r); check("R10 neighbour", r, 8'h21);
        // R12 data held without a read strobe
        repeat (3) @(negedge clk);
        check("R12 hold", bus_rdata, 8'h21);
        rd_byte(8'h60, r); check("R5 still", r, 8'hA5);

        // R2/R3 interrupt path, mask 0x05
        wr_byte(8'h52, 8'h05);
        sub_irq_in = 8'h02; @(negedge clk);
        check("R3 masked line", irq_out, 0);
        rd_byte(8'h50, r); check("R2 status", r, 8'h02);
        sub_irq_in = 8'h06; @(negedge clk);
        check("R3 unmasked line", irq_out, 1);
        sub_irq_in = 8'h00; @(negedge clk);
        check("R3 line low", irq_out, 0);
        rd_byte(8'h50, r); check("R2 status clear", r, 8'h00);

        // R7/R8/R9 output pins
        wr_byte(8'h7C, 8'h0F);
        check("R8 enable only", gpo_level, 0);
        check("R9 no change", gpo_change, 0);
        wr_byte(8'h78, 8'hFF);
        check("R8 level", gpo_level, 24'h00000F);
        check("R9 pulse", gpo_change, 24'h00000F);
        @(negedge clk);
        check("R9 pulse ends", gpo_change, 0);
        wr_byte(8'h78, 8'hFF);
        check("R9 same value", gpo_change, 0);
        wr_byte(8'h7E, 8'h80);
        check("R9 enable hi", gpo_change, 0);
        wr_byte(8'h7A, 8'h80);
        check("R9 pin 23", gpo_change, 24'h800000);
        check("R8 pin 23", gpo_level, 24'h80000F);
        wr_byte(8'h7C, 8'h03);
        check("R9 disable", gpo_change, 24'h00000C);
        check("R8 disable", gpo_level, 24'h800003);
        rd_byte(8'h7A, r); check("R7 data byte2", r, 8'h80);
        rd_byte(8'h7C, r); check("R7 enable byte0", r, 8'h03);
        rd_byte(8'h79, r); check("R7 data byte1", r, 8'h00);

        // R11 reset in the middle of operation
        sub_irq_in = 8'h01; wr_byte(8'h52, 8'h01);
        @(negedge clk);
        check("R3 before reset", irq_out, 1);
        rst_n = 1'b0; @(negedge clk);
        check("R11 level cleared", gpo_level, 0);
        check("R11 change none", gpo_change, 0);
        check("R11 irq cleared", irq_out, 0);
        sub_irq_in = 8'h00;
        rst_n = 1'b1; @(negedge clk);
        check("R11 no strobe", gpo_change, 0);
        rd_byte(8'h78, r); check("R11 data", r, 0);
        rd_byte(8'h61, r); check("R11 cfg high", r, 0);
        rd_byte(8'h52, r); check("R11 mask", r, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule